// File: doc/BRIEF.md
# Byte-Aliased Operand and Segment Register File

This block stores the architectural operand state of a 16-bit processor: eight word-wide operand registers and four word-wide segment registers. The first four operand registers can also be reached as eight independent bytes. Each byte shares storage with one half of its parent word, so a byte write merges into the word and leaves the other half alone.

The operand file has two combinational read ports and one write port. Each port carries a 3-bit register code and a size flag that selects byte or word access. A byte read returns the selected half zero-extended to 16 bits. The segment file has its own 2-bit-select read port and write port, and it is word-only. Writes take effect on the rising clock edge. A synchronous reset clears every register.

Top module: `byte_alias_regfile`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) sets all eight operand registers and all four segment registers to 0x0000.
- R2: Word codes are 0=AX, 1=CX, 2=DX, 3=BX, 4=SP, 5=BP, 6=SI, 7=DI. A word write stores all 16 bits of the write data, and a word read returns all 16 bits of the addressed register.
- R3: With the size flag set to byte, code bits [1:0] pick the parent word (0=AX, 1=CX, 2=DX, 3=BX) and code bit 2 picks the half: 0 means bits 7:0 (AL, CL, DL, BL), 1 means bits 15:8 (AH, CH, DH, BH).
- R4: A byte write stores write-data bits 7:0 into the selected half only. The other half of the parent word and every other register keep their values.
- R5: A byte read drives bits 15:8 of the read data to zero and bits 7:0 with the selected half.
- R6: Reads are combinational. A read of a register that is being written in the same cycle returns the old value, and the new value appears after the clock edge.
- R7: Both read ports work independently and at the same time, each with its own code and size flag.
- R8: Segment selects are 0=ES, 1=CS, 2=SS, 3=DS. The segment write port stores a full word, the segment read port returns a full word, and segment writes and operand writes never touch each other's registers.
- R9: With the operand write enable low, no operand register changes, whatever the write code, size and data are.
- R10: Reset takes priority over writes that are enabled in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all writes and reset act on its rising edge |
| rst | input | 1 | Synchronous reset, active high |
| a_code | input | 3 | Read port A register code |
| a_byte | input | 1 | Read port A size flag (1 = byte) |
| a_data | output | 16 | Read port A data |
| b_code | input | 3 | Read port B register code |
| b_byte | input | 1 | Read port B size flag (1 = byte) |
| b_data | output | 16 | Read port B data |
| w_en | input | 1 | Operand write enable |
| w_code | input | 3 | Operand write register code |
| w_byte | input | 1 | Operand write size flag (1 = byte) |
| w_data | input | 16 | Operand write data (bits 7:0 used for byte writes) |
| sg_rd_sel | input | 2 | Segment read select |
| sg_rd_data | output | 16 | Segment read data |
| sg_wr_en | input | 1 | Segment write enable |
| sg_wr_sel | input | 2 | Segment write select |
| sg_wr_data | input | 16 | Segment write data |

## Verification
The bench targets high-byte writes in particular. A design that routed bits 15:8 of the write data into AH, or that cleared the low half during the merge, would show a wrong word when the parent register is read back. It checks the byte code ordering (BL at code 3 and AH at code 4), where a plain linear byte order would hit the wrong register. It also checks that byte reads have a zero upper half, so a design that sign-extended or returned the whole word would fail. Finally, it reads a register during the same cycle in which that register is written, to catch a design that bypasses the write data to the read port, and it writes to one file (operand or segment) to catch writes that leak into the other file or into other lanes.

// File: rtl/arf_pkg.sv
package arf_pkg;

   // operand word codes
   typedef enum logic [2:0] {
      W_AX = 3'd0, W_CX = 3'd1, W_DX = 3'd2, W_BX = 3'd3,
      W_SP = 3'd4, W_BP = 3'd5, W_SI = 3'd6, W_DI = 3'd7
   } word_code_e;

   // operand byte codes (bit 2 picks the upper half)
   typedef enum logic [2:0] {
      B_AL = 3'd0, B_CL = 3'd1, B_DL = 3'd2, B_BL = 3'd3,
      B_AH = 3'd4, B_CH = 3'd5, B_DH = 3'd6, B_BH = 3'd7
   } byte_code_e;

   // segment selects
   typedef enum logic [1:0] {
      S_ES = 2'd0, S_CS = 2'd1, S_SS = 2'd2, S_DS = 2'd3
   } seg_code_e;

   // half-select helper: returns the upper or lower half of a word
   function automatic logic [7:0] pick_half8(input logic [15:0] w, input logic upper);
      return upper ? w[15:8] : w[7:0];
   endfunction

endpackage

// File: rtl/arf_write_dec.sv
module arf_write_dec #(
   parameter int GPR_COUNT   = 8,
   parameter int ALIAS_COUNT = 4,
   localparam int GPR_SEL_W   = $clog2(GPR_COUNT),
   localparam int ALIAS_SEL_W = $clog2(ALIAS_COUNT)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 w_en,
   input  logic [GPR_SEL_W-1:0] w_code,
   input  logic                 w_byte,
   output logic [GPR_COUNT-1:0] we_lo,
   output logic [GPR_COUNT-1:0] we_hi
);

   generate
      if (GPR_COUNT != 2 * ALIAS_COUNT) begin : g_bad_ratio
         $error("arf_write_dec: GPR_COUNT must be twice ALIAS_COUNT");
      end
      if (ALIAS_COUNT < 2 || (1 << ALIAS_SEL_W) != ALIAS_COUNT) begin : g_bad_alias
         $error("arf_write_dec: ALIAS_COUNT must be a power of two, at least 2");
      end
   endgenerate

   logic                   half_up;
   logic [ALIAS_SEL_W-1:0] byte_lane;

   assign half_up   = w_code[ALIAS_SEL_W];
   assign byte_lane = w_code[ALIAS_SEL_W-1:0];

   always_comb begin
      we_lo = '0;
      we_hi = '0;
      if (w_en) begin
         if (w_byte) begin
            if (half_up) we_hi[byte_lane] = 1'b1;
            else         we_lo[byte_lane] = 1'b1;
         end else begin
            we_lo[w_code] = 1'b1;
            we_hi[w_code] = 1'b1;
         end
      end
   end

   // R3: a byte write enables exactly one half of one lane
   p_one_half_r3: assert property (@(posedge clk) disable iff (rst)
      (w_en && w_byte) |-> ($countones({we_hi, we_lo}) == 1))
      else $error("p_one_half_r3");

   // R9: no enable, no lane strobe
   p_quiet_r9: assert property (@(posedge clk) disable iff (rst)
      !w_en |-> (we_lo == '0 && we_hi == '0))
      else $error("p_quiet_r9");

endmodule

// File: rtl/arf_cell.sv
module arf_cell #(
   parameter int  DATA_W  = 16,
   parameter bit  ALIASED = 1'b1,
   localparam int HALF_W  = DATA_W / 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              we_lo,
   input  logic              we_hi,
   input  logic [HALF_W-1:0] d_lo,
   input  logic [HALF_W-1:0] d_hi,
   output logic [DATA_W-1:0] q
);

   generate
      if (DATA_W % 2 != 0) begin : g_bad_width
         $error("arf_cell: DATA_W must be even");
      end

      if (ALIASED) begin : g_split
         logic [HALF_W-1:0] lo_q, hi_q;

         always_ff @(posedge clk) begin
            if (rst)        lo_q <= '0;
            else if (we_lo) lo_q <= d_lo;
         end

         always_ff @(posedge clk) begin
            if (rst)        hi_q <= '0;
            else if (we_hi) hi_q <= d_hi;
         end

         assign q = {hi_q, lo_q};

         // R4: a lower-half write keeps the upper half
         p_hi_kept_r4: assert property (@(posedge clk) disable iff (rst)
            (we_lo && !we_hi) |=> $stable(q[DATA_W-1:HALF_W]))
            else $error("p_hi_kept_r4");

         // R4: an upper-half write keeps the lower half
         p_lo_kept_r4: assert property (@(posedge clk) disable iff (rst)
            (we_hi && !we_lo) |=> $stable(q[HALF_W-1:0]))
            else $error("p_lo_kept_r4");
      end else begin : g_whole
         logic [DATA_W-1:0] w_q;

         always_ff @(posedge clk) begin
            if (rst)                 w_q <= '0;
            else if (we_lo && we_hi) w_q <= {d_hi, d_lo};
         end

         assign q = w_q;
      end
   endgenerate

endmodule

// File: rtl/arf_read_port.sv
module arf_read_port #(
   parameter int  DATA_W      = 16,
   parameter int  GPR_COUNT   = 8,
   parameter int  ALIAS_COUNT = 4,
   localparam int HALF_W      = DATA_W / 2,
   localparam int GPR_SEL_W   = $clog2(GPR_COUNT),
   localparam int ALIAS_SEL_W = $clog2(ALIAS_COUNT)
) (
   input  logic [GPR_COUNT-1:0][DATA_W-1:0] regs,
   input  logic [GPR_SEL_W-1:0]             code,
   input  logic                             is_byte,
   output logic [DATA_W-1:0]                data
);

   logic [DATA_W-1:0]      lane_word;
   logic [HALF_W-1:0]      lane_half;
   logic [ALIAS_SEL_W-1:0] lane_idx;
   logic                   upper;

   assign lane_idx  = code[ALIAS_SEL_W-1:0];
   assign upper     = code[ALIAS_SEL_W];
   assign lane_word = regs[lane_idx];
   assign lane_half = upper ? lane_word[DATA_W-1:HALF_W] : lane_word[HALF_W-1:0];

   always_comb begin
      if (is_byte) data = {{(DATA_W-HALF_W){1'b0}}, lane_half};
      else         data = regs[code];
   end

endmodule

// File: rtl/arf_seg_file.sv
module arf_seg_file #(
   parameter int  DATA_W    = 16,
   parameter int  SEG_COUNT = 4,
   localparam int SEG_SEL_W = $clog2(SEG_COUNT)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic                 wr_en,
   input  logic [SEG_SEL_W-1:0] wr_sel,
   input  logic [DATA_W-1:0]    wr_data,
   input  logic [SEG_SEL_W-1:0] rd_sel,
   output logic [DATA_W-1:0]    rd_data
);

   generate
      if (SEG_COUNT < 2 || (1 << SEG_SEL_W) != SEG_COUNT) begin : g_bad_seg
         $error("arf_seg_file: SEG_COUNT must be a power of two, at least 2");
      end
   endgenerate

   logic [SEG_COUNT-1:0][DATA_W-1:0] seg_q;

   for (genvar s = 0; s < SEG_COUNT; s++) begin : g_seg
      always_ff @(posedge clk) begin
         if (rst)                                       seg_q[s] <= '0;
         else if (wr_en && wr_sel == SEG_SEL_W'(s))     seg_q[s] <= wr_data;
      end
   end

   assign rd_data = seg_q[rd_sel];

   // R8: a segment write lands in the chosen slot
   p_seg_lands_r8: assert property (@(posedge clk) disable iff (rst)
      wr_en |=> (seg_q[$past(wr_sel)] == $past(wr_data)))
      else $error("p_seg_lands_r8");

   // R8: no segment write, no segment change
   p_seg_hold_r8: assert property (@(posedge clk) disable iff (rst)
      !wr_en |=> $stable(seg_q))
      else $error("p_seg_hold_r8");

endmodule

// File: rtl/byte_alias_regfile.sv
module byte_alias_regfile #(
   parameter int  DATA_W      = 16,
   parameter int  GPR_COUNT   = 8,
   parameter int  ALIAS_COUNT = 4,
   parameter int  SEG_COUNT   = 4,
   localparam int HALF_W      = DATA_W / 2,
   localparam int GPR_SEL_W   = $clog2(GPR_COUNT),
   localparam int SEG_SEL_W   = $clog2(SEG_COUNT)
) (
   input  logic                 clk,
   input  logic                 rst,
   input  logic [GPR_SEL_W-1:0] a_code,
   input  logic                 a_byte,
   output logic [DATA_W-1:0]    a_data,
   input  logic [GPR_SEL_W-1:0] b_code,
   input  logic                 b_byte,
   output logic [DATA_W-1:0]    b_data,
   input  logic                 w_en,
   input  logic [GPR_SEL_W-1:0] w_code,
   input  logic                 w_byte,
   input  logic [DATA_W-1:0]    w_data,
   input  logic [SEG_SEL_W-1:0] sg_rd_sel,
   output logic [DATA_W-1:0]    sg_rd_data,
   input  logic                 sg_wr_en,
   input  logic [SEG_SEL_W-1:0] sg_wr_sel,
   input  logic [DATA_W-1:0]    sg_wr_data
);

   logic [GPR_COUNT-1:0]             we_lo, we_hi;
   logic [GPR_COUNT-1:0][DATA_W-1:0] gpr_q;
   logic [HALF_W-1:0]                d_lo, d_hi;

   // a byte write always sources the low byte of the write data
   assign d_lo = w_data[HALF_W-1:0];
   assign d_hi = w_byte ? w_data[HALF_W-1:0] : w_data[DATA_W-1:HALF_W];

   arf_write_dec #(
      .GPR_COUNT   (GPR_COUNT),
      .ALIAS_COUNT (ALIAS_COUNT)
   ) i_dec (
      .clk    (clk),
      .rst    (rst),
      .w_en   (w_en),
      .w_code (w_code),
      .w_byte (w_byte),
      .we_lo  (we_lo),
      .we_hi  (we_hi)
   );

   for (genvar g = 0; g < GPR_COUNT; g++) begin : g_gpr
      arf_cell #(
         .DATA_W  (DATA_W),
         .ALIASED (g < ALIAS_COUNT)
      ) i_cell (
         .clk   (clk),
         .rst   (rst),
         .we_lo (we_lo[g]),
         .we_hi (we_hi[g]),
         .d_lo  (d_lo),
         .d_hi  (d_hi),
         .q     (gpr_q[g])
      );
   end

   arf_read_port #(
      .DATA_W      (DATA_W),
      .GPR_COUNT   (GPR_COUNT),
      .ALIAS_COUNT (ALIAS_COUNT)
   ) i_rd_a (
      .regs    (gpr_q),
      .code    (a_code),
      .is_byte (a_byte),
      .data    (a_data)
   );

   arf_read_port #(
      .DATA_W      (DATA_W),
      .GPR_COUNT   (GPR_COUNT),
      .ALIAS_COUNT (ALIAS_COUNT)
   ) i_rd_b (
      .regs    (gpr_q),
      .code    (b_code),
      .is_byte (b_byte),
      .data    (b_data)
   );

   arf_seg_file #(
      .DATA_W    (DATA_W),
      .SEG_COUNT (SEG_COUNT)
   ) i_seg (
      .clk     (clk),
      .rst     (rst),
      .wr_en   (sg_wr_en),
      .wr_sel  (sg_wr_sel),
      .wr_data (sg_wr_data),
      .rd_sel  (sg_rd_sel),
      .rd_data (sg_rd_data)
   );

   // R2: a word write is visible in full after the edge
   p_word_lands_r2: assert property (@(posedge clk) disable iff (rst)
      (w_en && !w_byte) |=> (gpr_q[$past(w_code)] == $past(w_data)))
      else $error("p_word_lands_r2");

   // R9: operand state holds when the write port is idle
   p_idle_hold_r9: assert property (@(posedge clk) disable iff (rst)
      !w_en |=> $stable(gpr_q))
      else $error("p_idle_hold_r9");

   // R5: byte reads on port A carry a zero upper half
   p_zext_a_r5: assert property (@(posedge clk) disable iff (rst)
      a_byte |-> (a_data[DATA_W-1:HALF_W] == '0))
      else $error("p_zext_a_r5");

   // R1: registers are zero in the cycle after reset
   p_reset_zero_r1: assert property (@(posedge clk)
      $past(rst) |-> (gpr_q == '0))
      else $error("p_reset_zero_r1");

endmodule

// File: tb/test_byte_alias_regfile.sv
module test_byte_alias_regfile;

   localparam int CLK_P = 10;

   logic        clk = 1'b0;
   logic        rst;
   logic [2:0]  a_code, b_code, w_code;
   logic        a_byte, b_byte, w_byte, w_en;
   logic [15:0] a_data, b_data, w_data;
   logic [1:0]  sg_rd_sel, sg_wr_sel;
   logic [15:0] sg_rd_data, sg_wr_data;
   logic        sg_wr_en;

   int          n_chk  = 0;
   int          n_fail = 0;

   logic [15:0] mdl [8];
   logic [15:0] smdl [4];

   always #(CLK_P/2) clk = ~clk;

   byte_alias_regfile i_byte_alias_regfile (
      .clk(clk), .rst(rst),
      .a_code(a_code), .a_byte(a_byte), .a_data(a_data),
      .b_code(b_code), .b_byte(b_byte), .b_data(b_data),
      .w_en(w_en), .w_code(w_code), .w_byte(w_byte), .w_data(w_data),
      .sg_rd_sel(sg_rd_sel), .sg_rd_data(sg_rd_data),
      .sg_wr_en(sg_wr_en), .sg_wr_sel(sg_wr_sel), .sg_wr_data(sg_wr_data)
   );

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // expected value of a read, from the code tables of R2/R3/R5
   function automatic logic [15:0] expect_rd(input logic [2:0] c, input logic b);
      if (!b) return mdl[c];
      return c[2] ? {8'h00, mdl[c[1:0]][15:8]} : {8'h00, mdl[c[1:0]][7:0]};
   endfunction

   task automatic rd_a(input logic [2:0] c, input logic b, input string req);
      a_code = c; a_byte = b; #1;
      chk(req, a_data, expect_rd(c, b));
   endtask

   task automatic rd_b(input logic [2:0] c, input logic b, input string req);
      b_code = c; b_byte = b; #1;
      chk(req, b_data, expect_rd(c, b));
   endtask

   task automatic wr(input logic [2:0] c, input logic b, input logic [15:0] d);
      @(negedge clk);
      w_en = 1'b1; w_code = c; w_byte = b; w_data = d;
      @(negedge clk);
      w_en = 1'b0;
      if (!b)        mdl[c] = d;
      else if (c[2]) mdl[c[1:0]][15:8] = d[7:0];
      else           mdl[c[1:0]][7:0]  = d[7:0];
   endtask

   task automatic sg_wr(input logic [1:0] s, input logic [15:0] d);
      @(negedge clk);
      sg_wr_en = 1'b1; sg_wr_sel = s; sg_wr_data = d;
      @(negedge clk);
      sg_wr_en = 1'b0;
      smdl[s] = d;
   endtask

   task automatic t_reset;
      @(negedge clk);
      rst = 1'b1;
      w_en = 1'b1; w_code = 3'd0; w_byte = 1'b0; w_data = 16'hFFFF;
      sg_wr_en = 1'b1; sg_wr_sel = 2'd1; sg_wr_data = 16'hFFFF;
      @(negedge clk);
      @(negedge clk);
      rst = 1'b0; w_en = 1'b0; sg_wr_en = 1'b0;
      for (int i = 0; i < 8; i++) mdl[i] = 16'h0000;
      for (int i = 0; i < 4; i++) smdl[i] = 16'h0000;
      for (int i = 0; i < 8; i++) rd_a(3'(i), 1'b0, "R1/R10 operand reset");
      for (int i = 0; i < 4; i++) begin
         sg_rd_sel = 2'(i); #1;
         chk("R1/R10 segment reset", sg_rd_data, 16'h0000);
      end
   endtask

   task automatic t_words;
      for (int i = 0; i < 8; i++) wr(3'(i), 1'b0, 16'h1000 * 16'(i + 1) + 16'h0F0F + 16'(i));
      for (int i = 0; i < 8; i++) begin
         rd_a(3'(i), 1'b0, "R2 word read A");
         rd_b(3'(7 - i), 1'b0, "R7 word read B");
      end
      // R2 code order: AX=0 and BX=3 hold specific values
      a_code = 3'd3; a_byte = 1'b0; #1;
      chk("R2 BX at code 3", a_data, 16'h4F12);
   endtask

   task automatic t_bytes;
      wr(3'd0, 1'b0, 16'hA1B2);
      wr(3'd0, 1'b1, 16'hEE11);           // AL <- 11
      a_code = 3'd0; a_byte = 1'b0; #1;
      chk("R4 AL merge", a_data, 16'hA111);
      wr(3'd4, 1'b1, 16'h9977);           // AH <- 77 (low byte of data)
      a_code = 3'd0; #1;
      chk("R4 AH merge", a_data, 16'h7711);
      wr(3'd3, 1'b0, 16'hC3D4);
      wr(3'd7, 1'b1, 16'h0055);           // BH <- 55
      wr(3'd3, 1'b1, 16'h0066);           // BL <- 66
      a_code = 3'd3; a_byte = 1'b0; #1;
      chk("R3 BH/BL map to code 3 word", a_data, 16'h5566);
      a_code = 3'd1; #1;
      chk("R4 CX untouched", a_data, mdl[1]);
      for (int i = 0; i < 8; i++) begin
         rd_a(3'(i), 1'b1, "R5 byte read A");
         rd_b(3'(i), 1'b1, "R5 byte read B");
      end
      b_code = 3'd5; b_byte = 1'b1; #1;
      chk("R3 CH upper half", b_data, {8'h00, mdl[1][15:8]});
   endtask

   task automatic t_same_cycle;
      @(negedge clk);
      w_en = 1'b1; w_code = 3'd2; w_byte = 1'b0; w_data = 16'h5A5A;
      a_code = 3'd2; a_byte = 1'b0; #1;
      chk("R6 old value before edge", a_data, mdl[2]);
      @(posedge clk); #1;
      w_en = 1'b0;
      mdl[2] = 16'h5A5A;
      chk("R6 new value after edge", a_data, 16'h5A5A);
   endtask

   task automatic t_idle;
      @(negedge clk);
      w_en = 1'b0; w_code = 3'd6; w_byte = 1'b0; w_data = 16'hDEAD;
      @(negedge clk);
      @(negedge clk);
      rd_a(3'd6, 1'b0, "R9 disabled write ignored");
   endtask

   task automatic t_segments;
      sg_wr(2'd0, 16'h1111);
      sg_wr(2'd1, 16'h2222);
      sg_wr(2'd2, 16'h3333);
      sg_wr(2'd3, 16'h4444);
      for (int i = 0; i < 4; i++) begin
         sg_rd_sel = 2'(i); #1;
         chk("R8 segment read", sg_rd_data, smdl[i]);
      end
      for (int i = 0; i < 8; i++) rd_a(3'(i), 1'b0, "R8 operands untouched by seg writes");
      wr(3'd5, 1'b0, 16'hBEEF);
      sg_rd_sel = 2'd2; #1;
      chk("R8 SS untouched by operand write", sg_rd_data, 16'h3333);
   endtask

   initial begin
      #(CLK_P * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst = 1'b1; w_en = 1'b0; w_code = '0; w_byte = 1'b0; w_data = '0;
      a_code = '0; a_byte = 1'b0; b_code = '0; b_byte = 1'b0;
      sg_rd_sel = '0; sg_wr_en = 1'b0; sg_wr_sel = '0; sg_wr_data = '0;
      for (int i = 0; i < 8; i++) mdl[i] = 16'h0000;
      for (int i = 0; i < 4; i++) smdl[i] = 16'h0000;
      t_reset;
      t_words;
      t_bytes;
      t_same_cycle;
      t_idle;
      t_segments;
      t_reset;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
   end

endmodule